// File: doc/BRIEF.md
# Banked Shadow Register File

This block is the integer general register file of a core that has a privileged firmware mode. It holds 31 architectural 64-bit registers behind two combinational read ports and one clocked write port. Next to the main array sits an eight-entry shadow bank. While the privileged-mode input is high, a fixed subset of register indices is steered to the shadow bank instead of the main array. Firmware can therefore use those registers freely without saving or disturbing the values that ordinary code left there. The shadow bank keeps its contents across mode changes.

Every access runs through the same index remapping, driven by the privileged flag of that cycle. The remapping turns an index into a location: the zero register, a main-array slot or a shadow slot. The two read ports compare their location with the location being written. When the two match, the read returns the incoming write data in the same cycle. Index 31 is a hard zero in both modes.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every index on both read ports reads zero in both modes, because both banks are cleared.
- R2: With privileged mode low, each index 0 to 30 selects its own main-array register, and a value written there is read back unchanged on a later cycle.
- R3: With privileged mode high, indices 8, 9, 10, 11, 12, 13 and 14 select shadow entries 0 through 6 in that order, for reads and for writes.
- R4: With privileged mode high, index 25 selects shadow entry 7, for reads and for writes.
- R5: With privileged mode high, indices 0 to 7, 15 to 24 and 26 to 30 still select the main array, so a write made in one mode is visible in the other.
- R6: The two banks are independent. A write through index 8 to 14 or 25 in one mode leaves the value seen through the same index in the other mode unchanged.
- R7: Index 31 always reads as zero, and a write to index 31 changes no register, in either mode.
- R8: When write enable is high and a read port addresses the location being written after remapping, that port returns the write data in the same cycle. With write enable low, or for a different location, the port returns the stored value.
- R9: The privileged flag is taken on each cycle on its own, so back-to-back writes to one index with the flag low and then high land in the main array and then the shadow bank.
- R10: The two read ports decode independently, so each returns the value of its own index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears both banks |
| priv_mode | input | 1 | High while the core runs privileged firmware; enables shadow steering for this cycle |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Register index written |
| wr_data | input | 64 | Data written |
| rd_idx_a | input | 5 | Register index of read port A |
| rd_idx_b | input | 5 | Register index of read port B |
| rd_data_a | output | 64 | Read data of port A (combinational) |
| rd_data_b | output | 64 | Read data of port B (combinational) |

## Verification
The bench first fills the main array with one data pattern in normal mode and the shadowed indices with a different pattern in privileged mode. It then reads every index in both modes, so a wrong shadow slot, a missing shadow range or a leak between the banks shows up as a value from the wrong pattern. Same-cycle read-during-write cases are driven with and without write enable and with the other port on a neighbouring index. These cases separate correct forwarding from forwarding on the raw index, forwarding with write enable low, and reads of stale data. Writes to index 31 and back-to-back writes that switch mode on each cycle show whether the zero register and the per-cycle mode sampling hold.

// File: rtl/rf_pkg.sv
package rf_pkg;

  localparam int IDX_W     = 5;
  localparam int ARCH_REGS = 31;
  localparam int ZERO_IDX  = 31;
  localparam int SH_REGS   = 8;
  localparam int SH_AW     = $clog2(SH_REGS);
  localparam int SH_LO     = 8;
  localparam int SH_HI     = 14;
  localparam int SH_EXTRA  = 25;

  // Where an index lands after remapping.
  typedef struct packed {
    logic             is_zero;
    logic             in_shadow;
    logic [IDX_W-1:0] main_a;
    logic [SH_AW-1:0] sh_a;
  } loc_t;

  function automatic loc_t map_reg(input logic [IDX_W-1:0] idx, input logic priv);
    loc_t l;
    logic in_range;
    logic is_extra;
    in_range    = (idx >= IDX_W'(SH_LO)) && (idx <= IDX_W'(SH_HI));
    is_extra    = (idx == IDX_W'(SH_EXTRA));
    l.is_zero   = (idx == IDX_W'(ZERO_IDX));
    l.in_shadow = priv && (in_range || is_extra);
    l.main_a    = idx;
    if (is_extra)      l.sh_a = SH_AW'(SH_REGS - 1);
    else if (in_range) l.sh_a = SH_AW'(idx - IDX_W'(SH_LO));
    else               l.sh_a = '0;
    return l;
  endfunction

  function automatic logic same_loc(input loc_t a, input loc_t b);
    logic slot_eq;
    slot_eq = a.in_shadow ? (a.sh_a == b.sh_a) : (a.main_a == b.main_a);
    return !a.is_zero && !b.is_zero && (a.in_shadow == b.in_shadow) && slot_eq;
  endfunction

endpackage

// File: rtl/rf_remap.sv
module rf_remap
  import rf_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  input  logic             priv_i,
  output loc_t             loc_o
);

  assign loc_o = map_reg(idx_i, priv_i);

  always_comb begin
    if (!priv_i)
      p_plain_r2: assert (!loc_o.in_shadow);
    if (priv_i && idx_i == IDX_W'(SH_EXTRA))
      p_extra_slot_r4: assert (loc_o.in_shadow && loc_o.sh_a == SH_AW'(SH_REGS - 1));
    if (priv_i && idx_i == IDX_W'(SH_LO))
      p_first_slot_r3: assert (loc_o.in_shadow && loc_o.sh_a == '0);
    if (idx_i == IDX_W'(ZERO_IDX))
      p_zero_map_r7: assert (loc_o.is_zero && !loc_o.in_shadow);
  end

endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 31,
  parameter int NRD    = 2,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [AW-1:0]               waddr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]      raddr,
  output logic [NRD-1:0][DATA_W-1:0]  rdata
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) mem_q[e] <= '0;
    end else if (we && int'(waddr) < DEPTH) begin
      mem_q[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (int'(raddr[p]) < DEPTH) ? mem_q[raddr[p]] : '0;
  end

  // A stored value is visible on the next cycle at the same slot.
  p_wr_then_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(we) && raddr[0] == $past(waddr) && int'(raddr[0]) < DEPTH)
      |-> rdata[0] == $past(wdata));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rf_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              priv_mode,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx_a,
  input  logic [IDX_W-1:0]  rd_idx_b,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b
);

  localparam int NRD = 2;

  logic [NRD-1:0][IDX_W-1:0]  rd_idx;
  loc_t                       wloc;
  loc_t                       rloc      [NRD];
  logic [NRD-1:0][IDX_W-1:0]  main_ra;
  logic [NRD-1:0][SH_AW-1:0]  sh_ra;
  logic [NRD-1:0][DATA_W-1:0] main_rd;
  logic [NRD-1:0][DATA_W-1:0] sh_rd;
  logic [NRD-1:0][DATA_W-1:0] rd_out;
  logic [NRD-1:0]             fwd_hit;
  logic                       wr_fire;
  logic                       main_we;
  logic                       sh_we;

  assign rd_idx = {rd_idx_b, rd_idx_a};

  rf_remap i_wmap (.idx_i(wr_idx), .priv_i(priv_mode), .loc_o(wloc));

  assign wr_fire = wr_en && !wloc.is_zero;
  assign main_we = wr_fire && !wloc.in_shadow;
  assign sh_we   = wr_fire &&  wloc.in_shadow;

  for (genvar p = 0; p < NRD; p++) begin : g_port
    rf_remap i_rmap (.idx_i(rd_idx[p]), .priv_i(priv_mode), .loc_o(rloc[p]));
    assign main_ra[p] = rloc[p].main_a;
    assign sh_ra[p]   = rloc[p].sh_a;
    assign fwd_hit[p] = wr_en && same_loc(wloc, rloc[p]);
    always_comb begin
      if (rloc[p].is_zero)        rd_out[p] = '0;
      else if (fwd_hit[p])        rd_out[p] = wr_data;
      else if (rloc[p].in_shadow) rd_out[p] = sh_rd[p];
      else                        rd_out[p] = main_rd[p];
    end
  end

  rf_bank #(.DATA_W(DATA_W), .DEPTH(ARCH_REGS), .NRD(NRD)) i_main (
    .clk(clk), .rst_n(rst_n), .we(main_we), .waddr(wloc.main_a),
    .wdata(wr_data), .raddr(main_ra), .rdata(main_rd));

  rf_bank #(.DATA_W(DATA_W), .DEPTH(SH_REGS), .NRD(NRD)) i_shadow (
    .clk(clk), .rst_n(rst_n), .we(sh_we), .waddr(wloc.sh_a),
    .wdata(wr_data), .raddr(sh_ra), .rdata(sh_rd));

  assign rd_data_a = rd_out[0];
  assign rd_data_b = rd_out[1];

  p_zero_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx_a == IDX_W'(ZERO_IDX) |-> rd_data_a == '0);

  p_zero_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_W'(ZERO_IDX)) |-> !main_we && !sh_we);

  p_fwd_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == rd_idx_a && wr_idx != IDX_W'(ZERO_IDX)) |-> rd_data_a == wr_data);

  p_extra_to_shadow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_mode && wr_en && wr_idx == IDX_W'(SH_EXTRA)) |-> sh_we && !main_we);

  p_user_to_main_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv_mode && wr_en && wr_idx != IDX_W'(ZERO_IDX)) |-> main_we && !sh_we);

endmodule

// File: tb/test_banked_regfile.sv
module test_banked_regfile;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        priv_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic [4:0]  rd_idx_a = '0;
  logic [4:0]  rd_idx_b = '0;
  logic [63:0] rd_data_a;
  logic [63:0] rd_data_b;

  int vectors = 0;
  int miscompares = 0;

  logic [63:0] m_user [31];
  logic [63:0] m_fw   [8];

  always #4 clk = ~clk;

  banked_regfile i_banked_regfile (
    .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b));

  // Shadow slot for an index in privileged mode, -1 if not steered (R3, R4).
  function automatic int fw_slot(input int idx);
    case (idx)
      8: return 0;   9: return 1;   10: return 2;  11: return 3;
      12: return 4;  13: return 5;  14: return 6;  25: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic logic [63:0] expect_val(input logic p, input int idx);
    if (idx == 31) return 64'd0;
    if (p && fw_slot(idx) >= 0) return m_fw[fw_slot(idx)];
    return m_user[idx];
  endfunction

  task automatic compare(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic p, input int idx, input logic [63:0] d);
    @(negedge clk);
    priv_mode = p; wr_en = 1'b1; wr_idx = 5'(idx); wr_data = d;
    @(posedge clk);
    if (idx != 31) begin
      if (p && fw_slot(idx) >= 0) m_fw[fw_slot(idx)] = d;
      else m_user[idx] = d;
    end
    #1 wr_en = 1'b0;
  endtask

  task automatic rd2(input logic p, input int a, input int b, input string req);
    @(negedge clk);
    priv_mode = p; wr_en = 1'b0; rd_idx_a = 5'(a); rd_idx_b = 5'(b);
    #2;
    compare($sformatf("%s port A idx %0d priv %0d", req, a, p), rd_data_a, expect_val(p, a));
    compare($sformatf("%s/R10 port B idx %0d priv %0d", req, b, p), rd_data_b, expect_val(p, b));
  endtask

  task automatic t_reset_r1;
    for (int i = 0; i < 32; i++) begin
      rd2(1'b0, i, 31 - i, "R1");
      rd2(1'b1, i, 31 - i, "R1");
    end
  endtask

  task automatic t_user_r2;
    for (int i = 0; i < 31; i++) wr(1'b0, i, 64'hA5A5_0000_0000_0000 | 64'(i * 7 + 1));
    for (int i = 0; i < 31; i++) rd2(1'b0, i, (i + 5) % 31, "R2");
  endtask

  task automatic t_shadow_r3_r4;
    for (int i = 8; i <= 14; i++) wr(1'b1, i, 64'h5A5A_0000_0000_0000 | 64'(i));
    wr(1'b1, 25, 64'h5A5A_0000_0000_0019);
    for (int i = 8; i <= 14; i++) rd2(1'b1, i, 25, "R3");
    rd2(1'b1, 25, 8, "R4");
    for (int i = 8; i <= 14; i++) rd2(1'b0, i, 25, "R6");
  endtask

  task automatic t_unshadowed_r5;
    for (int i = 0; i < 31; i++)
      if (fw_slot(i) < 0) rd2(1'b1, i, 30 - i, "R5");
    wr(1'b1, 3, 64'hC0DE_0000_0000_0003);
    rd2(1'b0, 3, 26, "R5");
    wr(1'b0, 20, 64'hC0DE_0000_0000_0014);
    rd2(1'b1, 20, 7, "R5");
  endtask

  task automatic t_isolate_r6;
    wr(1'b0, 10, 64'h1111_2222_3333_4444);
    rd2(1'b1, 10, 10, "R6");
    wr(1'b1, 25, 64'h9999_8888_7777_6666);
    rd2(1'b0, 25, 25, "R6");
    rd2(1'b1, 25, 10, "R6");
  endtask

  task automatic t_zero_r7;
    wr(1'b0, 31, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(1'b1, 31, 64'hEEEE_EEEE_EEEE_EEEE);
    rd2(1'b0, 31, 31, "R7");
    rd2(1'b1, 31, 31, "R7");
    for (int i = 0; i < 31; i++) rd2(1'b0, i, 31, "R7");
    for (int i = 8; i <= 14; i++) rd2(1'b1, i, 31, "R7");
    // Same-cycle read of index 31 while writing it.
    @(negedge clk);
    priv_mode = 1'b0; wr_en = 1'b1; wr_idx = 5'd31; wr_data = 64'h1234; rd_idx_a = 5'd31; rd_idx_b = 5'd31;
    #2;
    compare("R7 forward of idx 31 port A", rd_data_a, 64'd0);
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic fwd_case(input logic p, input int widx, input int a, input int b,
                          input logic en, input logic [63:0] d);
    logic [63:0] ea;
    logic [63:0] eb;
    @(negedge clk);
    priv_mode = p; wr_en = en; wr_idx = 5'(widx); wr_data = d; rd_idx_a = 5'(a); rd_idx_b = 5'(b);
    ea = (en && a == widx && a != 31) ? d : expect_val(p, a);
    eb = (en && b == widx && b != 31) ? d : expect_val(p, b);
    #2;
    compare($sformatf("R8 fwd port A w%0d r%0d en%0d priv %0d", widx, a, en, p), rd_data_a, ea);
    compare($sformatf("R8 fwd port B w%0d r%0d en%0d priv %0d", widx, b, en, p), rd_data_b, eb);
    @(posedge clk);
    if (en && widx != 31) begin
      if (p && fw_slot(widx) >= 0) m_fw[fw_slot(widx)] = d;
      else m_user[widx] = d;
    end
    #1 wr_en = 1'b0;
  endtask

  task automatic t_forward_r8;
    fwd_case(1'b0, 12, 12, 13, 1'b1, 64'hF00D_0000_0000_000C);
    fwd_case(1'b1, 12, 12, 13, 1'b1, 64'hBEEF_0000_0000_000C);
    fwd_case(1'b1, 25, 24, 25, 1'b1, 64'hBEEF_0000_0000_0019);
    fwd_case(1'b0, 6,  6,  6,  1'b0, 64'hDEAD_0000_0000_0006);
    fwd_case(1'b1, 2,  2,  1,  1'b1, 64'hCAFE_0000_0000_0002);
    rd2(1'b0, 12, 25, "R8");
    rd2(1'b1, 12, 25, "R8");
  endtask

  task automatic t_toggle_r9;
    @(negedge clk);
    wr_en = 1'b1; priv_mode = 1'b0; wr_idx = 5'd13; wr_data = 64'h0101_0101_0101_0101;
    @(posedge clk);
    m_user[13] = 64'h0101_0101_0101_0101;
    @(negedge clk);
    priv_mode = 1'b1; wr_data = 64'h0202_0202_0202_0202;
    @(posedge clk);
    m_fw[5] = 64'h0202_0202_0202_0202;
    @(negedge clk);
    priv_mode = 1'b0; wr_data = 64'h0303_0303_0303_0303;
    @(posedge clk);
    m_user[13] = 64'h0303_0303_0303_0303;
    #1 wr_en = 1'b0;
    rd2(1'b0, 13, 14, "R9");
    rd2(1'b1, 13, 14, "R9");
  endtask

  initial begin
    for (int i = 0; i < 31; i++) m_user[i] = '0;
    for (int i = 0; i < 8; i++) m_fw[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset_r1();
    t_user_r2();
    t_shadow_r3_r4();
    t_unshadowed_r5();
    t_isolate_r6();
    t_zero_r7();
    t_forward_r8();
    t_toggle_r9();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule